// File: doc/BRIEF.md
# Bit-Masked Shared Output Port

This block holds one output port register that several processor contexts share. A context selects the bits it owns by writing a mask to a dedicated mask address on the IO bus. After that, its writes to the port address change only the bits set in its own mask. Its reads of the port address return the input pins with every bit outside its mask forced to zero.

Each context has its own mask register, selected by the context ID that travels with every bus access. Several independent routines can therefore drive separate bits of one port, such as LEDs that blink at unrelated rates. No routine needs a read-modify-write sequence, and no routine can disturb the bits of another. The time-slotted bus allows at most one access per cycle, so the block needs no arbitration.

Reads are registered. The read value appears on `busRdata` in the cycle after the read strobe and is zero in any cycle that follows a non-read.

Top module: `shared_bitport`

## Requirements
- R1: After reset, `pinsOut` is 0, `busRdata` is 0, and every context's mask is all ones (0xFFFF).
- R2: A write with `busAddr` equal to the mask address (default 1) stores `busWdata` as the mask of context `busCtx`. A read of the mask address returns that context's mask on `busRdata` one cycle later.
- R3: A write to the port address (default 0) makes `pinsOut` equal to `(old & ~mask) | (busWdata & mask)` at the next clock edge, using the writing context's mask.
- R4: A port write leaves every `pinsOut` bit outside the writer's mask unchanged.
- R5: A read of the port address returns `pinsIn & mask` of the reading context on `busRdata` in the next cycle. Unmasked bits read as zero.
- R6: A mask write by one context leaves the masks of all other contexts unchanged.
- R7: An access to any address other than the port and mask addresses leaves `pinsOut` and all masks unchanged, and a read there returns zero.
- R8: In the cycle after any cycle without a read (idle or write), `busRdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (4) | IO address |
| busCtx | input | CTX_W (2) | Context ID of the access |
| busWdata | input | PORT_W (16) | Write data |
| busRdata | output | PORT_W (16) | Registered read data |
| pinsIn | input | PORT_W (16) | Input pins |
| pinsOut | output | PORT_W (16) | Output port register |

## Verification
The bench builds the block with its defaults: four contexts, a 16-bit port, and mask and port addresses 1 and 0. With these values, every context can hold a disjoint nibble mask at the same time, so the bench can interleave writes that set and clear each nibble and check that no other nibble moves. The 4-bit address space leaves spare addresses for the unmapped-access case. The 2-bit context ID reaches every mask register, so the readback after reset and after programming covers all four masks.

// File: rtl/shared_bitport_pkg.sv
package shared_bitport_pkg;
  typedef struct packed {
    logic maskWe;
    logic portWe;
    logic maskRd;
    logic portRd;
  } bitportStrobes_t;
endpackage

// File: rtl/bitport_ctrl.sv
module bitport_ctrl
  import shared_bitport_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MASK_ADDR = 1,
  parameter int PORT_ADDR = 0
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output bitportStrobes_t   strobes
);
  localparam logic [ADDR_W-1:0] MaskSel = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] PortSel = ADDR_W'(PORT_ADDR);

  logic hitMask;
  logic hitPort;

  always_comb begin
    hitMask        = busValid && (busAddr == MaskSel);
    hitPort        = busValid && (busAddr == PortSel);
    strobes.maskWe = hitMask && busWrite;
    strobes.portWe = hitPort && busWrite;
    strobes.maskRd = hitMask && !busWrite;
    strobes.portRd = hitPort && !busWrite;
  end
endmodule

// File: rtl/bitport_dpath.sv
module bitport_dpath
  import shared_bitport_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int PORT_W  = 16,
  parameter int CTX_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bitportStrobes_t   strobes,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pinsIn,
  output logic [PORT_W-1:0] pinsOut,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] curMask
);
  logic [PORT_W-1:0] maskReg [NUM_CTX];
  logic [PORT_W-1:0] portReg;
  logic [PORT_W-1:0] rdReg;
  logic [PORT_W-1:0] rdNext;

  for (genvar g = 0; g < NUM_CTX; g++) begin : gen_mask
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskReg[g] <= '1;
      end else if (strobes.maskWe && (ctx == CTX_W'(g))) begin
        maskReg[g] <= wdata;
      end
    end
  end

  always_comb begin
    curMask = maskReg[ctx];
    if (strobes.portRd) begin
      rdNext = pinsIn & curMask;
    end else if (strobes.maskRd) begin
      rdNext = curMask;
    end else begin
      rdNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portReg <= '0;
      rdReg   <= '0;
    end else begin
      rdReg <= rdNext;
      if (strobes.portWe) begin
        portReg <= (portReg & ~curMask) | (wdata & curMask);
      end
    end
  end

  assign pinsOut = portReg;
  assign rdata   = rdReg;
endmodule

// File: rtl/shared_bitport.sv
module shared_bitport
  import shared_bitport_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int PORT_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int MASK_ADDR = 1,
  parameter int PORT_ADDR = 0,
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CTX_W-1:0]  busCtx,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] pinsIn,
  output logic [PORT_W-1:0] pinsOut
);
  bitportStrobes_t   strobes;
  logic [PORT_W-1:0] curMask;

  bitport_ctrl #(
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .PORT_ADDR(PORT_ADDR)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .strobes(strobes)
  );

  bitport_dpath #(
    .NUM_CTX(NUM_CTX), .PORT_W(PORT_W), .CTX_W(CTX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctx(busCtx),
    .wdata(busWdata), .pinsIn(pinsIn), .pinsOut(pinsOut),
    .rdata(busRdata), .curMask(curMask)
  );
endmodule

// File: rtl/bitport_checker.sv
module bitport_checker #(
  parameter int PORT_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int PORT_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PORT_W-1:0] busWdata,
  input logic [PORT_W-1:0] busRdata,
  input logic [PORT_W-1:0] pinsIn,
  input logic [PORT_W-1:0] pinsOut,
  input logic [PORT_W-1:0] curMask
);
  logic portWrite;
  logic portRead;
  logic anyRead;
  assign portWrite = busValid && busWrite && (busAddr == ADDR_W'(PORT_ADDR));
  assign portRead  = busValid && !busWrite && (busAddr == ADDR_W'(PORT_ADDR));
  assign anyRead   = busValid && !busWrite;

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (pinsOut == '0) && (busRdata == '0));

  assert_masked_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    portWrite |=> ((pinsOut ^ $past(busWdata)) & $past(curMask)) == '0);

  assert_keep_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    portWrite |=> ((pinsOut ^ $past(pinsOut)) & ~$past(curMask)) == '0);

  assert_read_port_R5: assert property (@(posedge clk) disable iff (!rstN)
    portRead |=> busRdata == ($past(pinsIn) & $past(curMask)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !portWrite |=> $stable(pinsOut));

  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rstN)
    !anyRead |=> busRdata == '0);
endmodule

bind shared_bitport bitport_checker #(
  .PORT_W(PORT_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .pinsIn(pinsIn), .pinsOut(pinsOut), .curMask(curMask)
);

// File: tb/shared_bitport_tb.sv
module shared_bitport_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] PORT_A = 4'd0;
  localparam logic [3:0] MASK_A = 4'd1;

  typedef struct {
    logic [15:0] expOut;
    logic [15:0] expRd;
    string       req;
  } item_t;

  logic        clk = 0;
  logic        rstN = 0;
  logic        busValid = 0;
  logic        busWrite = 0;
  logic [3:0]  busAddr = '0;
  logic [1:0]  busCtx = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] pinsIn = '0;
  logic [15:0] pinsOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t q[$];
  logic [15:0] mdlMask [4];
  logic [15:0] mdlPort;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bitport u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busCtx(busCtx), .busWdata(busWdata),
    .busRdata(busRdata), .pinsIn(pinsIn), .pinsOut(pinsOut)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [3:0] addr, logic [1:0] ctx,
                        logic [15:0] data, string req);
    item_t it;
    @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = addr; busCtx = ctx; busWdata = data;
    it.expRd = '0;
    if (!wr && addr == PORT_A) it.expRd = pinsIn & mdlMask[ctx];
    if (!wr && addr == MASK_A) it.expRd = mdlMask[ctx];
    if (wr && addr == PORT_A) mdlPort = (mdlPort & ~mdlMask[ctx]) | (data & mdlMask[ctx]);
    if (wr && addr == MASK_A) mdlMask[ctx] = data;
    it.expOut = mdlPort;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(string req);
    item_t it;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    it.expOut = mdlPort; it.expRd = '0; it.req = req;
    q.push_back(it);
  endtask

  // monitor: compares outputs one step after the edge that consumed each access
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({it.req, " pinsOut"}, pinsOut, it.expOut);
      check({it.req, " busRdata"}, busRdata, it.expRd);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdlMask[i] = 16'hFFFF;
    mdlPort = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pinsOut", pinsOut, 16'h0);
    check("R1 reset busRdata", busRdata, 16'h0);
    @(negedge clk); rstN = 1;
    // R1: masks reset to all ones
    for (int c = 0; c < 4; c++) access(0, MASK_A, 2'(c), 16'h0, "R1 mask reset");
    // R3: unmasked write
    access(1, PORT_A, 0, 16'h1234, "R3 full write");
    // R2/R6: each context owns one nibble
    access(1, MASK_A, 0, 16'h000F, "R2 mask ctx0");
    access(1, MASK_A, 1, 16'h00F0, "R2 mask ctx1");
    access(1, MASK_A, 2, 16'h0F00, "R2 mask ctx2");
    access(1, MASK_A, 3, 16'hF000, "R2 mask ctx3");
    for (int c = 0; c < 4; c++) access(0, MASK_A, 2'(c), 16'h0, "R6 mask readback");
    // R4: masked writes leave other bits
    access(1, PORT_A, 1, 16'hFFFF, "R4 ctx1 set");
    access(1, PORT_A, 2, 16'h0000, "R4 ctx2 clear");
    access(1, PORT_A, 3, 16'hA5A5, "R3 ctx3 write");
    // R6: interleaved toggling at different rates
    for (int k = 0; k < 24; k++) begin
      access(1, PORT_A, 2'(k % 4), (k % 3 == 0) ? 16'hFFFF : 16'h0000, "R6 blink");
      if (k % 5 == 0) idle("R8 idle");
    end
    // R5: masked reads
    @(negedge clk); pinsIn = 16'hA5C3;
    for (int c = 0; c < 4; c++) access(0, PORT_A, 2'(c), 16'h0, "R5 port read");
    access(1, MASK_A, 2, 16'h0FF0, "R2 mask change");
    access(0, PORT_A, 2, 16'h0, "R5 read new mask");
    // R7: unmapped addresses
    access(1, 4'd5, 1, 16'hFFFF, "R7 stray write");
    access(0, 4'd9, 0, 16'h0, "R7 stray read");
    access(0, MASK_A, 1, 16'h0, "R7 mask intact");
    // R8: write cycle then idle
    access(1, PORT_A, 0, 16'h0003, "R8 after write");
    idle("R8 idle");
    idle("R8 idle");
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule